// File: doc/BRIEF.md
# PCI Power Management Register Logic

This block holds the power-management state of one PCI function and presents it through a plain 32-bit configuration read/write port. It provides two dwords. The first is a read-only capability header. The second is a control/status register that carries a wake-status flag, a wake enable bit and a two-bit device power state. The block drives an active-low wake request pin. It raises a flag that confines the function to configuration traffic whenever it is out of D0. It also pulses a soft reset for the function's other read-write configuration bits when software brings the device from D3 back to D0.

Two resets act on the block. The power-on reset clears everything. The host reset clears the power state every time, but clears the wake bits only when cold-state wake support is off. That support is on when both the capability-bit-15 strap and the S3 enable input are high. Reads are combinational from the offset. Writes take effect at the clock edge, one byte lane at a time.

The power state is kept in a four-state machine with states `PS_D0`, `PS_D1`, `PS_D2` and `PS_D3`. Its transitions are:
- **direct move**: any state goes to any state on a write through byte lane 0.
- **restore**: the move from `PS_D3` to `PS_D0`, which also fires the soft reset.
- **host return**: host reset sends any state to `PS_D0`.

Top module: `pm_cap_regs`

## Requirements
- R1: Offset 0x40 always reads 32'hFE02_0001, and writes to it change nothing.
- R2: Power-on reset leaves every control/status bit at 0, the wake pin high (inactive), the config-only flag low and the soft reset low.
- R3: A wake event sets the status flag (offset 0x44 bit 15) whatever the enable is. Writing 1 to bit 15 with lane 1 enabled clears it, and writing 0 leaves it unchanged.
- R4: When a wake event and a write-1-to-clear of the status fall in the same cycle, the status reads 1 afterwards.
- R5: The wake pin is low exactly while the status flag and the enable (bit 8) are both 1.
- R6: When capability bit 15 and S3 enable are both 1, a host reset keeps the status and the enable. The power state still returns to D0 with no soft reset pulse.
- R7: When cold-state wake support is off, a host reset clears the status and the enable. Writes made while host reset is low are ignored in every case.
- R8: Bits 1:0 of offset 0x44 hold the power state: 00 = D0, 01 = D1, 10 = D2, 11 = D3. They read back as written, and the config-only flag is high while they are not 00.
- R9: A write that moves the power state from D3 to D0 raises the soft reset for exactly the one cycle after that write's edge. Other moves (D2 to D0, D3 to D3, D3 to D1, D0 to D0) give no pulse, and the pulse leaves the status and the enable as they were.
- R10: Lane 0 updates only the power state, and lane 1 updates only the enable and the status clear. Lanes 2 and 3 have no effect. Bits 31:16, 14:9 and 7:2 of offset 0x44 read 0.
- R11: Any offset other than 0x40 and 0x44 reads 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| hrst_n | input | 1 | Host reset, synchronous, active low |
| cap_d3c | input | 1 | Capability bit 15 strap (wake from D3cold supported) |
| s3_en | input | 1 | S3 wake enable from the platform |
| wake_evt | input | 1 | Wake event, sampled at the clock edge |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset (dword aligned) |
| cfg_be | input | 4 | Write byte enables |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_addr |
| pme_n | output | 1 | Wake request, active low |
| cfg_only | output | 1 | High while the function must accept configuration accesses only |
| cfg_soft_rst | output | 1 | One-cycle reset for the other read-write configuration bits |

## Verification
Two pairs of functions can meet in one cycle. The first pair is the wake set and the software clear of the status. The second is the D3-to-D0 restore write and a host reset, or a wake event that arrives during that restore. The bench drives these collisions on purpose: a wake pulse on the same edge as a write-1-to-clear, a host reset held over a restore write, and a wake on the restore edge itself. A random phase then adds more of them. A behavioural model in the bench predicts the status, the pin, the flag and the pulse on every clock and compares them with the outputs, so the model's rule decides each collision.

// File: rtl/pm_pkg.sv
package pm_pkg;

    typedef enum logic [1:0] {
        PS_D0 = 2'b00,
        PS_D1 = 2'b01,
        PS_D2 = 2'b10,
        PS_D3 = 2'b11
    } pstate_e;

    localparam int STS_BIT = 15;
    localparam int ENA_BIT = 8;
    localparam int PS_LSB  = 0;

endpackage

// File: rtl/pm_cfg_decode.sv
module pm_cfg_decode #(
    parameter int          ADDR_W  = 8,
    parameter logic [7:0]  CAP_OFF = 8'h40
) (
    input  logic              hrst_n,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [1:0]        lane_be,
    output logic              cap_sel,
    output logic              csr_sel,
    output logic [1:0]        lane_we
);
    localparam logic [ADDR_W-1:0] CAP_A = ADDR_W'(CAP_OFF);
    localparam logic [ADDR_W-1:0] CSR_A = ADDR_W'(CAP_OFF + 8'd4);

    always_comb begin
        cap_sel = (cfg_addr == CAP_A);
        csr_sel = (cfg_addr == CSR_A);
    end

    for (genvar g = 0; g < 2; g++) begin : g_lane
        assign lane_we[g] = cfg_wr & csr_sel & lane_be[g] & hrst_n;
    end
endmodule

// File: rtl/pm_wake_bits.sv
module pm_wake_bits (
    input  logic clk,
    input  logic por_n,
    input  logic hrst_n,
    input  logic keep,
    input  logic wake_evt,
    input  logic lane1_we,
    input  logic sts_w1c,
    input  logic ena_val,
    output logic sts,
    output logic ena
);
    logic clr_req;
    assign clr_req = lane1_we & sts_w1c;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            sts <= 1'b0;
            ena <= 1'b0;
        end else if (!hrst_n && !keep) begin
            sts <= 1'b0;
            ena <= 1'b0;
        end else begin
            sts <= wake_evt | (sts & ~clr_req);
            if (lane1_we) begin
                ena <= ena_val;
            end
        end
    end
endmodule

// File: rtl/pm_pstate_fsm.sv
module pm_pstate_fsm
    import pm_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  logic       hrst_n,
    input  logic       lane0_we,
    input  logic [1:0] ps_req,
    output logic [1:0] ps_rd,
    output logic       cfg_only,
    output logic       soft_rst
);
    pstate_e state, state_n;
    logic    restore;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state    <= PS_D0;
            soft_rst <= 1'b0;
        end else if (!hrst_n) begin
            state    <= PS_D0;
            soft_rst <= 1'b0;
        end else begin
            state    <= state_n;
            soft_rst <= restore;
        end
    end

    always_comb begin
        state_n  = state;
        restore  = 1'b0;
        cfg_only = 1'b1;
        unique case (state)
            PS_D0: begin
                cfg_only = 1'b0;
                if (lane0_we) state_n = pstate_e'(ps_req);
            end
            PS_D1, PS_D2: begin
                if (lane0_we) state_n = pstate_e'(ps_req);
            end
            PS_D3: begin
                if (lane0_we) begin
                    state_n = pstate_e'(ps_req);
                    restore = (pstate_e'(ps_req) == PS_D0);
                end
            end
            default: state_n = PS_D0;
        endcase
    end

    assign ps_rd = state;
endmodule

// File: rtl/pm_cap_regs.sv
module pm_cap_regs
    import pm_pkg::*;
#(
    parameter int          ADDR_W    = 8,
    parameter int          DATA_W    = 32,
    parameter logic [7:0]  CAP_OFF   = 8'h40,
    parameter logic [31:0] CAP_VALUE = 32'hFE02_0001
) (
    input  logic                clk,
    input  logic                por_n,
    input  logic                hrst_n,
    input  logic                cap_d3c,
    input  logic                s3_en,
    input  logic                wake_evt,
    input  logic                cfg_wr,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic [DATA_W/8-1:0] cfg_be,
    input  logic [DATA_W-1:0]   cfg_wdata,
    output logic [DATA_W-1:0]   cfg_rdata,
    output logic                pme_n,
    output logic                cfg_only,
    output logic                cfg_soft_rst
);
    logic       cap_sel, csr_sel;
    logic [1:0] lane_we;
    logic       sts, ena, keep;
    logic [1:0] ps_rd;

    assign keep = cap_d3c & s3_en;

    pm_cfg_decode #(.ADDR_W(ADDR_W), .CAP_OFF(CAP_OFF)) u_dec (
        .hrst_n  (hrst_n),
        .cfg_wr  (cfg_wr),
        .cfg_addr(cfg_addr),
        .lane_be (cfg_be[1:0]),
        .cap_sel (cap_sel),
        .csr_sel (csr_sel),
        .lane_we (lane_we)
    );

    pm_wake_bits u_wake (
        .clk     (clk),
        .por_n   (por_n),
        .hrst_n  (hrst_n),
        .keep    (keep),
        .wake_evt(wake_evt),
        .lane1_we(lane_we[1]),
        .sts_w1c (cfg_wdata[STS_BIT]),
        .ena_val (cfg_wdata[ENA_BIT]),
        .sts     (sts),
        .ena     (ena)
    );

    pm_pstate_fsm u_fsm (
        .clk     (clk),
        .por_n   (por_n),
        .hrst_n  (hrst_n),
        .lane0_we(lane_we[0]),
        .ps_req  (cfg_wdata[PS_LSB+1:PS_LSB]),
        .ps_rd   (ps_rd),
        .cfg_only(cfg_only),
        .soft_rst(cfg_soft_rst)
    );

    always_comb begin
        cfg_rdata = '0;
        if (cap_sel) begin
            cfg_rdata = DATA_W'(CAP_VALUE);
        end else if (csr_sel) begin
            cfg_rdata[STS_BIT]         = sts;
            cfg_rdata[ENA_BIT]         = ena;
            cfg_rdata[PS_LSB+1:PS_LSB] = ps_rd;
        end
    end

    assign pme_n = ~(sts & ena);
endmodule

// File: rtl/pm_cap_regs_chk.sv
module pm_cap_regs_chk #(
    parameter int          ADDR_W    = 8,
    parameter int          DATA_W    = 32,
    parameter logic [7:0]  CAP_OFF   = 8'h40,
    parameter logic [31:0] CAP_VALUE = 32'hFE02_0001
) (
    input logic                clk,
    input logic                por_n,
    input logic                hrst_n,
    input logic                cap_d3c,
    input logic                s3_en,
    input logic                cfg_wr,
    input logic [ADDR_W-1:0]   cfg_addr,
    input logic [DATA_W/8-1:0] cfg_be,
    input logic [DATA_W-1:0]   cfg_wdata,
    input logic [DATA_W-1:0]   cfg_rdata,
    input logic                pme_n,
    input logic                cfg_only,
    input logic                cfg_soft_rst
);
    localparam logic [ADDR_W-1:0] CAP_A = ADDR_W'(CAP_OFF);
    localparam logic [ADDR_W-1:0] CSR_A = ADDR_W'(CAP_OFF + 8'd4);

    // R1
    assert_cap_ro_R1: assert property (@(posedge clk) disable iff (!por_n)
        (cfg_wr && cfg_addr == CAP_A && cfg_wdata != DATA_W'(CAP_VALUE))
        |=> (cfg_addr != CAP_A || cfg_rdata == DATA_W'(CAP_VALUE)));

    // R5
    assert_pme_hold_R5: assert property (@(posedge clk) disable iff (!por_n)
        (!pme_n && hrst_n && !(cfg_wr && cfg_addr == CSR_A && cfg_be[1]))
        |=> !pme_n);

    // R6
    assert_hrst_d0_R6: assert property (@(posedge clk) disable iff (!por_n)
        !hrst_n |=> (!cfg_only && !cfg_soft_rst));

    // R7
    assert_nonsticky_R7: assert property (@(posedge clk) disable iff (!por_n)
        (!hrst_n && !(cap_d3c && s3_en)) |=> pme_n);

    // R9
    assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!por_n)
        cfg_soft_rst |=> !cfg_soft_rst);

    // R9
    assert_pulse_cause_R9: assert property (@(posedge clk) disable iff (!por_n)
        cfg_soft_rst |-> $past(cfg_wr && cfg_addr == CSR_A && cfg_be[0]
                               && cfg_wdata[1:0] == 2'b00 && cfg_only && hrst_n));

    // R9
    assert_pulse_d0_R9: assert property (@(posedge clk) disable iff (!por_n)
        cfg_soft_rst |-> !cfg_only);

    // R10
    assert_rsvd_zero_R10: assert property (@(posedge clk) disable iff (!por_n)
        (cfg_addr == CSR_A) |-> (cfg_rdata[DATA_W-1:16] == '0
                                 && cfg_rdata[14:9] == '0 && cfg_rdata[7:2] == '0));

    // R11
    assert_unmapped_R11: assert property (@(posedge clk) disable iff (!por_n)
        (cfg_addr != CAP_A && cfg_addr != CSR_A) |-> (cfg_rdata == '0));
endmodule

bind pm_cap_regs pm_cap_regs_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CAP_OFF(CAP_OFF), .CAP_VALUE(CAP_VALUE)
) u_chk (
    .clk         (clk),
    .por_n       (por_n),
    .hrst_n      (hrst_n),
    .cap_d3c     (cap_d3c),
    .s3_en       (s3_en),
    .cfg_wr      (cfg_wr),
    .cfg_addr    (cfg_addr),
    .cfg_be      (cfg_be),
    .cfg_wdata   (cfg_wdata),
    .cfg_rdata   (cfg_rdata),
    .pme_n       (pme_n),
    .cfg_only    (cfg_only),
    .cfg_soft_rst(cfg_soft_rst)
);

// File: tb/test_pm_cap_regs.sv
`timescale 1ns/1ps
module test_pm_cap_regs;
    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        hrst_n = 1'b1;
    logic        cap_d3c = 1'b0;
    logic        s3_en = 1'b0;
    logic        wake_evt = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_addr = 8'h00;
    logic [3:0]  cfg_be = 4'h0;
    logic [31:0] cfg_wdata = 32'h0;
    logic [31:0] cfg_rdata;
    logic        pme_n, cfg_only, cfg_soft_rst;

    int    vectors = 0;
    int    miscompares = 0;
    bit    done = 1'b0;
    string tag = "R2";

    // behavioural reference state
    int m_sts = 0, m_ena = 0, m_ps = 0, m_pulse = 0;

    always #4 clk = ~clk;   // 125 MHz

    pm_cap_regs i_pm_cap_regs (
        .clk(clk), .por_n(por_n), .hrst_n(hrst_n), .cap_d3c(cap_d3c), .s3_en(s3_en),
        .wake_evt(wake_evt), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pme_n(pme_n),
        .cfg_only(cfg_only), .cfg_soft_rst(cfg_soft_rst)
    );

    always @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            m_sts = 0; m_ena = 0; m_ps = 0; m_pulse = 0;
        end else if (!hrst_n) begin
            m_ps = 0; m_pulse = 0;
            if (cap_d3c && s3_en) begin
                if (wake_evt) m_sts = 1;
            end else begin
                m_sts = 0; m_ena = 0;
            end
        end else begin
            bit hit;
            hit = cfg_wr && cfg_addr == 8'h44;
            m_pulse = (hit && cfg_be[0] && m_ps == 3 && cfg_wdata[1:0] == 2'b00) ? 1 : 0;
            if (hit && cfg_be[1] && cfg_wdata[15]) m_sts = 0;
            if (wake_evt) m_sts = 1;
            if (hit && cfg_be[1]) m_ena = cfg_wdata[8];
            if (hit && cfg_be[0]) m_ps = cfg_wdata[1:0];
        end
    end

    function automatic logic [31:0] exp_rd(input logic [7:0] a);
        if (a == 8'h40) return 32'hFE02_0001;
        if (a == 8'h44) return {16'h0, 1'(m_sts), 6'h0, 1'(m_ena), 6'h0, 2'(m_ps)};
        return 32'h0;
    endfunction

    task automatic cmp(input string what, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
        cmp("rdata", cfg_rdata, exp_rd(cfg_addr));
        cmp("pme_n", 32'(pme_n), 32'((m_sts && m_ena) ? 0 : 1));
        cmp("cfg_only", 32'(cfg_only), 32'(m_ps != 0));
        cmp("soft_rst", 32'(cfg_soft_rst), 32'(m_pulse));
    endtask

    task automatic wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
        cfg_wr = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
        tick();
        cfg_wr = 1'b0; cfg_be = 4'h0;
        cfg_addr = 8'h44;
        tick();
    endtask

    task automatic rd(input logic [7:0] a);
        cfg_wr = 1'b0; cfg_addr = a;
        tick();
    endtask

    task automatic set_ps(input int p);
        wr(8'h44, 4'b0001, 32'(p));
    endtask

    task automatic pulse_wake();
        wake_evt = 1'b1; tick(); wake_evt = 1'b0;
    endtask

    initial begin
        // R2: power-on state
        tag = "R2";
        repeat (3) tick();
        por_n = 1'b1;
        rd(8'h44); rd(8'h40);

        // R1: read-only capability dword
        tag = "R1";
        wr(8'h40, 4'hF, 32'h1234_5678);
        rd(8'h40);

        // R8: power state encoding and config-only flag
        tag = "R8";
        for (int p = 1; p < 4; p++) begin set_ps(p); rd(8'h44); end
        set_ps(2); set_ps(1); set_ps(0); rd(8'h44);

        // R3: wake sets status with enable low; W1C semantics
        tag = "R3";
        pulse_wake(); rd(8'h44);
        wr(8'h44, 4'b0010, 32'h0000_0000);
        wr(8'h44, 4'b0010, 32'h0000_8000);
        rd(8'h44);

        // R5: pin follows status and enable
        tag = "R5";
        wr(8'h44, 4'b0010, 32'h0000_0100);
        pulse_wake(); rd(8'h44);
        wr(8'h44, 4'b0010, 32'h0000_8100);
        pulse_wake();
        wr(8'h44, 4'b0010, 32'h0000_0000);
        wr(8'h44, 4'b0010, 32'h0000_0100);

        // R4: set and clear on one edge
        tag = "R4";
        wake_evt = 1'b1;
        wr(8'h44, 4'b0010, 32'h0000_8100);
        wake_evt = 1'b0;
        rd(8'h44);

        // R9: restore pulse and non-restore moves
        tag = "R9";
        set_ps(3); set_ps(0);
        set_ps(2); set_ps(0);
        set_ps(3); set_ps(3); set_ps(1); set_ps(0); set_ps(0);
        set_ps(3);
        wake_evt = 1'b1; set_ps(0); wake_evt = 1'b0;
        rd(8'h44);

        // R10: byte lanes
        tag = "R10";
        wr(8'h44, 4'b1100, 32'hFFFF_FFFF);
        wr(8'h44, 4'b0010, 32'hFFFF_FEFF);
        wr(8'h44, 4'b0001, 32'hFFFF_FFFE);
        wr(8'h44, 4'b0011, 32'h0000_8103);
        set_ps(0);

        // R6: sticky wake bits across host reset
        tag = "R6";
        cap_d3c = 1'b1; s3_en = 1'b1;
        wr(8'h44, 4'b0010, 32'h0000_0100);
        pulse_wake(); set_ps(3);
        hrst_n = 1'b0;
        cfg_wr = 1'b1; cfg_addr = 8'h44; cfg_be = 4'b0011; cfg_wdata = 32'h0000_8000;
        tick(); tick();
        cfg_wr = 1'b0; hrst_n = 1'b1;
        rd(8'h44);

        // R7: non-sticky clearing, writes ignored in host reset
        tag = "R7";
        s3_en = 1'b0;
        set_ps(2);
        hrst_n = 1'b0;
        wake_evt = 1'b1;
        cfg_wr = 1'b1; cfg_be = 4'b0011; cfg_wdata = 32'h0000_0103;
        tick();
        wake_evt = 1'b0; cfg_wr = 1'b0; hrst_n = 1'b1;
        rd(8'h44);

        // R11: unmapped offsets
        tag = "R11";
        rd(8'h48); rd(8'h00); rd(8'h3C);
        wr(8'h48, 4'hF, 32'hFFFF_FFFF);
        rd(8'h44);

        // R3: random mix of all functions
        tag = "R3";
        for (int i = 0; i < 600; i++) begin
            int r;
            r = int'($urandom_range(0, 15));
            cap_d3c  = $urandom_range(0, 1) == 1;
            s3_en    = $urandom_range(0, 1) == 1;
            hrst_n   = $urandom_range(0, 15) != 0;
            wake_evt = $urandom_range(0, 5) == 0;
            cfg_wr   = $urandom_range(0, 1) == 1;
            cfg_addr = (r < 12) ? 8'h44 : ((r < 14) ? 8'h40 : 8'h4C);
            cfg_be   = 4'($urandom_range(0, 15));
            cfg_wdata = $urandom;
            tick();
        end
        cfg_wr = 1'b0; wake_evt = 1'b0; hrst_n = 1'b1;
        tick();

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog run did not complete");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule